// File: doc/BRIEF.md
# Memory Type Range Resolver

This block maps a physical address range to the memory type that governs it. A query gives a start address and an exclusive end address. One cycle later the block returns an 8-bit type code. The code comes from one of three stores: a default-type setting, a table of fixed-size slots that covers the first mebibyte, and a set of programmable base/mask region pairs.

Several regions may cover the same address. In that case their types are merged by a fixed precedence. A query can also run across the edge of a region. Then the block returns the type of the leading portion only, together with the exclusive end of that portion and a repeat flag. A surrounding controller can then issue a follow-up query for the remainder.

Register programming has three write ports: a control word, a fixed-slot byte and a base or mask word. A write takes effect for queries sampled on later clock edges.

Top module: `memtype_resolver`

## Requirements
- R1: `r_valid` pulses high exactly one cycle after each cycle with `q_valid` high. While `q_valid` is low, `r_type`, `r_repeat` and `r_part_end` hold their previous values. After reset `r_type` is 0xFF and `r_repeat`/`r_part_end` are 0.
- R2: The answer is 0xFF with `r_repeat`=0 in two cases: no control write has happened since reset, or the enable field `ctl_en` last written is 2'b00.
- R3: When fixed slots exist and start < 0x100000, the type is the fixed slot picked by the start address alone, whatever `ctl_en[0]` holds. Slots 0–7 cover 64 KiB each from 0. Slots 8–23 cover 16 KiB each from 0x80000. Slots 24–87 cover 4 KiB each from 0xC0000. A slot write with an index of 88 or more is ignored.
- R4: Outside the fixed zone, when `ctl_en[1]` (variable enable) is 0, the answer is the default type.
- R5: A region takes part only when bit 11 of its mask word is set. It covers address a when (a & M) == (B & M), where M and B are the mask and base with bits [11:0] cleared. Its type is base bits [7:0]. Writes select base with `var_mask_sel`=0 and mask with `var_mask_sel`=1.
- R6: When variable ranges are enabled but no region covers the start, the answer is the default type.
- R7: Covering regions are merged in index order. A type of 0 (uncacheable) on either side gives 0 and ends the merge. A pair of 6 and 4 gives 4. Any other differing pair gives 0 and ends the merge. Equal types keep that type.
- R8: The inclusive end is (end − 1). A region covers exactly one of start and the current inclusive end. If it covers the start, the split point is base+size, where size = −M. Otherwise the split point is base. The inclusive end becomes split−1, `r_repeat` rises and `r_part_end` returns the split. Later regions see the shortened end.
- R9: A split point not above the start is replaced by start + 0x1000.
- R10: Without a split, `r_part_end` equals the query's exclusive end and `r_repeat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_def_type | input | 8 | Default type to store |
| ctl_en | input | 2 | Enable field; bit 1 enables variable regions |
| fix_we | input | 1 | Fixed slot write strobe |
| fix_slot | input | 7 | Fixed slot index |
| fix_type | input | 8 | Type byte for the slot |
| var_we | input | 1 | Region register write strobe |
| var_mask_sel | input | 1 | 0 writes base, 1 writes mask |
| var_idx | input | IDX_W | Region index |
| var_wdata | input | ADDR_W | Base or mask word |
| q_valid | input | 1 | Query strobe |
| q_start | input | ADDR_W | Query start address |
| q_end | input | ADDR_W | Query exclusive end address |
| r_valid | output | 1 | Answer strobe |
| r_type | output | 8 | Resolved type |
| r_repeat | output | 1 | Answer covers only the leading portion |
| r_part_end | output | ADDR_W | Exclusive end of the answered portion |

## Verification
The bench builds the block with a 32-bit address width, four regions and the fixed table present. With these values the split arithmetic wraps at 2^32. That wrap is what lets a region whose base+size overflows to zero trigger the forced one-page split point. Four regions are enough to stack an invalid entry, a write-back/write-through pair and a split region on top of one another. Every fixed slot band is reached, including the last 4 KiB slot below 1 MiB and a query whose end lies past the fixed zone.

// File: rtl/memtype_pkg.sv
`timescale 1ns/1ps
package memtype_pkg;
    localparam int PG_BITS   = 12;
    localparam int VALID_BIT = 11;
    localparam int VAR_EN    = 1;
    localparam int FIX_SLOTS = 88;
    localparam int SLOT_W    = 7;

    localparam logic [7:0] MT_UC   = 8'h00;
    localparam logic [7:0] MT_WT   = 8'h04;
    localparam logic [7:0] MT_WB   = 8'h06;
    localparam logic [7:0] MT_NONE = 8'hFF;

    // Slot chosen by an address below 1 MiB: three bands of finer granularity.
    function automatic logic [SLOT_W-1:0] fix_slot_of(input logic [19:0] a);
        if (!a[19])
            return {4'd0, a[18:16]};
        else if (!a[18])
            return 7'd8 + {3'd0, a[17:14]};
        else
            return 7'd24 + {1'b0, a[17:12]};
    endfunction
endpackage

// File: rtl/mtr_fixed_bank.sv
`timescale 1ns/1ps
module mtr_fixed_bank
    import memtype_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [7:0]        wr_type,
    input  logic [19:0]       rd_addr,
    output logic [7:0]        rd_type
);
    logic [FIX_SLOTS-1:0][7:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_slot) < FIX_SLOTS))
            tbl_d[wr_slot] = wr_type;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_type = tbl_q[fix_slot_of(rd_addr)];
endmodule

// File: rtl/mtr_var_bank.sv
`timescale 1ns/1ps
module mtr_var_bank #(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8,
    parameter int IDX_W   = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_mask_sel,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [ADDR_W-1:0]               wr_data,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]  base_q,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]  mask_q
);
    logic [NUM_VAR-1:0][ADDR_W-1:0] base_d, mask_d;

    always_comb begin
        base_d = base_q;
        mask_d = mask_q;
        if (wr_en && (int'(wr_idx) < NUM_VAR)) begin
            if (wr_mask_sel) mask_d[wr_idx] = wr_data;
            else             base_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else begin
            base_q <= base_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/mtr_var_scan.sv
`timescale 1ns/1ps
module mtr_var_scan
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic [ADDR_W-1:0]               start,
    input  logic [ADDR_W-1:0]               end_incl,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0]  base,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0]  mask,
    output logic                            any_hit,
    output logic [7:0]                      hit_type,
    output logic                            split,
    output logic [ADDR_W-1:0]               end_incl_o
);
    localparam logic [ADDR_W-1:0] PG_KEEP  = {{(ADDR_W-PG_BITS){1'b1}}, {PG_BITS{1'b0}}};
    localparam logic [ADDR_W-1:0] PG_STEP  = {{(ADDR_W-PG_BITS-1){1'b0}}, 1'b1, {PG_BITS{1'b0}}};
    localparam logic [ADDR_W-1:0] ONE_A    = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        logic [ADDR_W-1:0] cur_end, b, m, pe;
        logic [7:0]        acc, cur;
        logic              stop, s_in, e_in;
        cur_end = end_incl;
        acc     = MT_NONE;
        stop    = 1'b0;
        split   = 1'b0;
        b = '0; m = '0; pe = '0; cur = '0; s_in = 1'b0; e_in = 1'b0;
        for (int i = 0; i < NUM_VAR; i++) begin
            b    = base[i] & PG_KEEP;
            m    = mask[i] & PG_KEEP;
            cur  = base[i][7:0];
            s_in = ((start & m) == (b & m));
            e_in = ((cur_end & m) == (b & m));
            if (!stop && mask[i][VALID_BIT]) begin
                if (s_in != e_in) begin
                    pe = s_in ? (b + (~m + ONE_A)) : b;
                    if (pe <= start) pe = start + PG_STEP;
                    cur_end = pe - ONE_A;
                    split   = 1'b1;
                end
                if (s_in) begin
                    if (acc == MT_NONE) begin
                        acc = cur;
                    end else if (acc == MT_UC || cur == MT_UC) begin
                        acc  = MT_UC;
                        stop = 1'b1;
                    end else if ((acc == MT_WB && cur == MT_WT) ||
                                 (acc == MT_WT && cur == MT_WB)) begin
                        acc = MT_WT;
                    end else if (acc != cur) begin
                        acc  = MT_UC;
                        stop = 1'b1;
                    end
                end
            end
        end
        any_hit    = (acc != MT_NONE);
        hit_type   = acc;
        end_incl_o = cur_end;
    end
endmodule

// File: rtl/memtype_resolver.sv
`timescale 1ns/1ps
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int ADDR_W    = 36,
    parameter int NUM_VAR   = 8,
    parameter int HAS_FIXED = 1,
    parameter int IDX_W     = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_def_type,
    input  logic [1:0]        ctl_en,
    input  logic              fix_we,
    input  logic [6:0]        fix_slot,
    input  logic [7:0]        fix_type,
    input  logic              var_we,
    input  logic              var_mask_sel,
    input  logic [IDX_W-1:0]  var_idx,
    input  logic [ADDR_W-1:0] var_wdata,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_start,
    input  logic [ADDR_W-1:0] q_end,
    output logic              r_valid,
    output logic [7:0]        r_type,
    output logic              r_repeat,
    output logic [ADDR_W-1:0] r_part_end
);
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [7:0]        def_type;
        logic [1:0]        en;
        logic              cfg;
        logic              rv;
        logic [7:0]        rtype;
        logic              rrep;
        logic [ADDR_W-1:0] rend;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_VAR-1:0][ADDR_W-1:0] base_w, mask_w;
    logic [ADDR_W-1:0] end_incl, scan_end;
    logic [7:0]        scan_type, fix_rd;
    logic              scan_hit, scan_rep, in_fixed;

    assign end_incl = q_end - ONE_A;

    mtr_var_bank #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .IDX_W(IDX_W)) u_vbank (
        .clk(clk), .rst_n(rst_n), .wr_en(var_we), .wr_mask_sel(var_mask_sel),
        .wr_idx(var_idx), .wr_data(var_wdata), .base_q(base_w), .mask_q(mask_w)
    );

    mtr_var_scan #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_scan (
        .start(q_start), .end_incl(end_incl), .base(base_w), .mask(mask_w),
        .any_hit(scan_hit), .hit_type(scan_type), .split(scan_rep),
        .end_incl_o(scan_end)
    );

    generate
        if (HAS_FIXED != 0) begin : g_fix
            mtr_fixed_bank u_fbank (
                .clk(clk), .rst_n(rst_n), .wr_en(fix_we), .wr_slot(fix_slot),
                .wr_type(fix_type), .rd_addr(q_start[19:0]), .rd_type(fix_rd)
            );
            assign in_fixed = (q_start[ADDR_W-1:20] == '0);
        end else begin : g_nofix
            assign fix_rd   = MT_NONE;
            assign in_fixed = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.rv = q_valid;
        if (ctl_we) begin
            st_d.def_type = ctl_def_type;
            st_d.en       = ctl_en;
            st_d.cfg      = 1'b1;
        end
        if (q_valid) begin
            st_d.rrep = 1'b0;
            st_d.rend = q_end;
            if (!st_q.cfg || st_q.en == 2'b00) begin
                st_d.rtype = MT_NONE;
            end else if (in_fixed) begin
                st_d.rtype = fix_rd;
            end else if (!st_q.en[VAR_EN]) begin
                st_d.rtype = st_q.def_type;
            end else begin
                st_d.rtype = scan_hit ? scan_type : st_q.def_type;
                st_d.rrep  = scan_rep;
                st_d.rend  = scan_end + ONE_A;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rtype <= MT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_valid    = st_q.rv;
    assign r_type     = st_q.rtype;
    assign r_repeat   = st_q.rrep;
    assign r_part_end = st_q.rend;
endmodule

// File: rtl/memtype_resolver_chk.sv
`timescale 1ns/1ps
module memtype_resolver_chk #(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [1:0]        ctl_en,
    input logic              q_valid,
    input logic [ADDR_W-1:0] q_start,
    input logic [ADDR_W-1:0] q_end,
    input logic              r_valid,
    input logic [7:0]        r_type,
    input logic              r_repeat,
    input logic [ADDR_W-1:0] r_part_end
);
    logic       seen_q;
    logic [1:0] last_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_en_q <= 2'b00;
        end else if (ctl_we) begin
            seen_q    <= 1'b1;
            last_en_q <= ctl_en;
        end
    end

    // R1
    answer_follows_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> r_valid);
    // R1
    idle_holds_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> (!r_valid && $stable(r_type) && $stable(r_repeat) && $stable(r_part_end)));
    // R2
    unconfigured_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && (!seen_q || last_en_q == 2'b00)) |=> (r_type == 8'hFF && !r_repeat));
    // R9
    split_above_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> (!r_repeat || r_part_end > $past(q_start)));
    // R10
    whole_range_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> (r_repeat || r_part_end == $past(q_end)));
endmodule

bind memtype_resolver memtype_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .q_valid(q_valid), .q_start(q_start), .q_end(q_end),
    .r_valid(r_valid), .r_type(r_type), .r_repeat(r_repeat),
    .r_part_end(r_part_end)
);

// File: tb/memtype_resolver_tb.sv
`timescale 1ns/1ps
module memtype_resolver_tb;
    localparam int AW = 32;
    localparam int NV = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ctl_we = 0, fix_we = 0, var_we = 0, var_mask_sel = 0, q_valid = 0;
    logic [7:0]    ctl_def_type = 0, fix_type = 0;
    logic [1:0]    ctl_en = 0;
    logic [6:0]    fix_slot = 0;
    logic [IW-1:0] var_idx = 0;
    logic [AW-1:0] var_wdata = 0, q_start = 0, q_end = 0;
    logic          r_valid, r_repeat;
    logic [7:0]    r_type;
    logic [AW-1:0] r_part_end;

    memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .HAS_FIXED(1), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_def_type(ctl_def_type),
        .ctl_en(ctl_en), .fix_we(fix_we), .fix_slot(fix_slot), .fix_type(fix_type),
        .var_we(var_we), .var_mask_sel(var_mask_sel), .var_idx(var_idx),
        .var_wdata(var_wdata), .q_valid(q_valid), .q_start(q_start), .q_end(q_end),
        .r_valid(r_valid), .r_type(r_type), .r_repeat(r_repeat), .r_part_end(r_part_end)
    );

    // behavioural model state
    logic [7:0]    m_fix [88];
    logic [AW-1:0] m_base [NV];
    logic [AW-1:0] m_mask [NV];
    logic [7:0]    m_def = 0;
    logic [1:0]    m_en = 0;
    bit            m_cfg = 0;

    bit            e_valid = 0, e_rep = 0, running = 0;
    logic [7:0]    e_type = 8'hFF;
    logic [AW-1:0] e_end = 0;
    string         e_tag = "R1 reset";
    int            checks = 0, errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_lookup(input logic [AW-1:0] s, input logic [AW-1:0] e,
                                       output logic [7:0] t, output bit rep, output logic [AW-1:0] pe);
        logic [AW-1:0] ei, b, mk, p;
        logic [7:0] prev, ct;
        bit ss, es;
        ei = e - 1; pe = e; rep = 0; prev = 8'hFF;
        if (!m_cfg || m_en == 0) begin t = 8'hFF; return; end
        if (s < 32'h100000) begin
            int k;
            if (s < 32'h80000)      k = int'(s >> 16);
            else if (s < 32'hC0000) k = 8 + int'((s - 32'h80000) >> 14);
            else                    k = 24 + int'((s - 32'hC0000) >> 12);
            t = m_fix[k];
            return;
        end
        if (!m_en[1]) begin t = m_def; return; end
        for (int i = 0; i < NV; i++) begin
            if (!m_mask[i][11]) continue;
            b  = m_base[i] & 32'hFFFFF000;
            mk = m_mask[i] & 32'hFFFFF000;
            ss = ((s & mk) == (b & mk));
            es = ((ei & mk) == (b & mk));
            if (ss != es) begin
                p = ss ? b + (0 - mk) : b;
                if (p <= s) p = s + 32'h1000;
                ei = p - 1; pe = p; rep = 1;
            end
            if (!ss) continue;
            ct = m_base[i][7:0];
            if (prev == 8'hFF) begin prev = ct; continue; end
            if (prev == 0 || ct == 0) begin t = 0; return; end
            if ((prev == 6 && ct == 4) || (prev == 4 && ct == 6)) prev = 4;
            else if (prev != ct) begin t = 0; return; end
        end
        t = (prev != 8'hFF) ? prev : m_def;
    endfunction

    // compare on every clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (running) begin
            chk("R1", {63'd0, r_valid}, {63'd0, e_valid}, "valid");
            chk(e_tag, {56'd0, r_type}, {56'd0, e_type}, "type");
            chk(e_tag, {63'd0, r_repeat}, {63'd0, e_rep}, "repeat");
            chk(e_tag, {32'd0, r_part_end}, {32'd0, e_end}, "part_end");
        end
    end

    task automatic clear_inputs();
        ctl_we = 0; fix_we = 0; var_we = 0; q_valid = 0; e_valid = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] d, input logic [1:0] en);
        @(negedge clk); clear_inputs();
        ctl_we = 1; ctl_def_type = d; ctl_en = en;
        m_def = d; m_en = en; m_cfg = 1;
    endtask

    task automatic wr_fix(input int slot, input logic [7:0] t);
        @(negedge clk); clear_inputs();
        fix_we = 1; fix_slot = 7'(slot); fix_type = t;
        if (slot < 88) m_fix[slot] = t;
    endtask

    task automatic wr_var(input int idx, input bit msel, input logic [AW-1:0] d);
        @(negedge clk); clear_inputs();
        var_we = 1; var_mask_sel = msel; var_idx = IW'(idx); var_wdata = d;
        if (msel) m_mask[idx] = d; else m_base[idx] = d;
    endtask

    task automatic query(input logic [AW-1:0] s, input logic [AW-1:0] e, input string tag);
        logic [7:0] t; bit rp; logic [AW-1:0] pe;
        @(negedge clk); clear_inputs();
        q_valid = 1; q_start = s; q_end = e;
        ref_lookup(s, e, t, rp, pe);
        e_valid = 1; e_type = t; e_rep = rp; e_end = pe; e_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk); clear_inputs();
    endtask

    bit finished = 0;
    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 88; i++) m_fix[i] = 0;
        for (int i = 0; i < NV; i++) begin m_base[i] = 0; m_mask[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        idle();
        // R1 reset state checked by the monitor with e_type=FF, e_end=0
        query(32'h0000_1000, 32'h0000_2000, "R2 unconfigured");
        idle();
        wr_ctl(8'h06, 2'b00);
        query(32'h1000_0000, 32'h1000_1000, "R2 enable zero");
        // fixed slots
        wr_fix(0, 8'h05); wr_fix(1, 8'h01); wr_fix(7, 8'h01); wr_fix(8, 8'h04);
        wr_fix(23, 8'h00); wr_fix(24, 8'h06); wr_fix(87, 8'h02); wr_fix(95, 8'h03);
        // variable regions
        wr_var(0, 0, 32'h1000_0006); wr_var(0, 1, 32'hF000_0800);
        wr_var(1, 0, 32'h1000_0004); wr_var(1, 1, 32'hFF00_0800);
        wr_var(2, 0, 32'h2000_0001); wr_var(2, 1, 32'hF000_0800);
        wr_var(3, 0, 32'h2000_0000); wr_var(3, 1, 32'hF000_0000);
        wr_ctl(8'h05, 2'b11);
        query(32'h0000_0000, 32'h0000_1000, "R3 slot0");
        query(32'h0000_F000, 32'h0001_0000, "R3 slot0 top");
        query(32'h0007_F000, 32'h0008_0000, "R3 slot7");
        query(32'h0008_0000, 32'h0008_1000, "R3 slot8");
        query(32'h0008_4000, 32'h0008_5000, "R3 slot9 reset");
        query(32'h000B_C000, 32'h000C_0000, "R3 slot23");
        query(32'h000C_0000, 32'h000C_1000, "R3 slot24");
        query(32'h000F_F000, 32'h0020_0000, "R3 slot87 long");
        idle();
        wr_ctl(8'h05, 2'b10);
        query(32'h0001_0000, 32'h0001_1000, "R3 bit0 clear");
        wr_ctl(8'h05, 2'b01);
        query(32'h1800_0000, 32'h1800_1000, "R4 variable off");
        wr_ctl(8'h05, 2'b11);
        query(32'h1800_0000, 32'h1800_1000, "R5 single region");
        query(32'h2000_0000, 32'h2000_1000, "R5 invalid ignored");
        query(32'h4000_0000, 32'h4000_1000, "R6 no region");
        query(32'h1000_0000, 32'h1000_1000, "R7 wb wt pair");
        query(32'h1F00_0000, 32'h2100_0000, "R8 start inside");
        query(32'h0F00_0000, 32'h1100_0000, "R8 start outside");
        query(32'h1800_0000, 32'h1800_2000, "R10 whole range");
        idle(); idle();
        wr_var(3, 1, 32'hF000_0800);
        query(32'h2000_0000, 32'h2000_1000, "R7 uncacheable wins");
        wr_var(3, 0, 32'h2000_0006);
        query(32'h2000_0000, 32'h2000_1000, "R7 differing pair");
        wr_var(3, 0, 32'h2000_0001);
        query(32'h2000_0000, 32'h2000_1000, "R7 equal pair");
        wr_var(3, 0, 32'h4000_0006); wr_var(3, 1, 32'h4000_0800);
        query(32'h7000_0000, 32'h8000_1000, "R9 forced page");
        idle(); idle(); idle();
        running = 0;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule